// File: doc/BRIEF.md
# Divided Reference Clock Generator with Cycle-Step Phase Selection

This block runs from a single fast reference clock and produces two slower square waves that are locked to it: a middle-rate wave at one third of the reference rate and a low-rate wave at one thirty-sixth of it. The low-rate wave is built by counting whole periods of the middle-rate wave, twelve of them per low-rate period. Each rate is available in two forms. The continuous form always runs from the reference alignment. The shifted form is the same wave delayed by a programmable whole number of reference cycles.

Software-side logic programs a delay through a small write port: a select bit picks the rate and a data word carries the delay. The value only sits in a staging register and changes nothing on the outputs. A separate load strobe later moves both staged delays into the active registers at once. On that same edge the shifted counters are re-seeded to their new phase, and the continuous waves are left untouched. Values outside the legal range are refused and flagged. The staged and active delays are both visible on output ports, and a pending flag shows that a staged value is waiting for a load.

Top module: `bucket_divgen`

## Requirements
- R1: `cw_mid` repeats a 3-cycle pattern of 2 reference cycles high followed by 1 cycle low, and no command changes it.
- R2: `cw_low` repeats a 36-cycle pattern of 18 cycles high and 18 cycles low. Each of its rising edges falls on the same edge as a rising edge of `cw_mid`. No command changes it.
- R3: `sh_mid` and `sh_low` equal `cw_mid` and `cw_low` delayed by the active delay in reference cycles (`active_mid`, `active_low`). With an active delay of 0 they are identical to the continuous outputs.
- R4: A write with `wr_en`=1 and `wr_sel`=0 targets the middle-rate delay (legal 0 to 2). With `wr_sel`=1 it targets the low-rate delay (legal 0 to 35). A legal value appears on `staged_mid` or `staged_low` one cycle later and changes neither the active delays nor any output.
- R5: On the edge that samples `load_strb`=1, both active delays take the staged values held before that edge. The shifted outputs follow the new delay from the next cycle onward, without a pulse shorter than one reference cycle.
- R6: A write above the legal range leaves the staged value unchanged and drives `wr_err` high for exactly the one cycle after the write.
- R7: `pending` goes high after an accepted write and goes low after a load that has no write in the same cycle. When a write and a load share a cycle, the load uses the older staged value and `pending` stays high.
- R8: While `rst_n` is low, all delays are cleared to 0 and all counters are aligned, so all four wave outputs are high in the reset cycle and start their high phase together.
- R9: Every low-rate delay from 0 to 35 is accepted and produces the matching delay on `sh_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write a delay value into the staging register |
| wr_sel | input | 1 | Target select: 0 middle rate, 1 low rate |
| wr_data | input | 6 | Delay in reference cycles |
| load_strb | input | 1 | Copy both staged delays to the active registers |
| cw_mid | output | 1 | Continuous divide-by-3 wave |
| cw_low | output | 1 | Continuous divide-by-36 wave |
| sh_mid | output | 1 | Shifted divide-by-3 wave |
| sh_low | output | 1 | Shifted divide-by-36 wave |
| staged_mid | output | 2 | Staged middle-rate delay |
| staged_low | output | 6 | Staged low-rate delay |
| active_mid | output | 2 | Active middle-rate delay |
| active_low | output | 6 | Active low-rate delay |
| pending | output | 1 | Staged value written but not yet loaded |
| wr_err | output | 1 | One-cycle flag after a rejected write |

## Verification
The bench sweeps every low-rate delay, including the values that are not multiples of three. A seed computed from the middle-rate count alone would put `sh_low` off by up to two cycles on those values. It writes just past each legal limit (3, 36 and 63), where an off-by-one range check would accept the value and corrupt the staged register. It issues a write and a load in the same cycle, where a design that forwards the fresh data would apply the wrong delay or drop `pending`. It also leaves staged values unloaded for long stretches, so any leak from staging into the outputs appears as a phase mismatch. Finally, it resets in the middle of a run with non-zero delays, to catch counters or delays that survive reset misaligned.

// File: rtl/bdg_pkg.sv
// Package: shared helpers for the divided reference clock generator.
// Assumes: callers pass positive counts.
package bdg_pkg;

    // Bits needed to hold values 0 .. n-1 (at least one bit).
    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bdg_mod_counter.sv
// Module: modulo-PERIOD counter with clock enable and synchronous re-seed.
// Assumes: seed_val is already below PERIOD; seeding wins over counting.
module bdg_mod_counter #(
    parameter int PERIOD = 3,
    parameter int W      = bdg_pkg::bits_for(PERIOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         seed_en,
    input  logic [W-1:0] seed_val,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    // Count state: clear on reset, load on seed, else wrap-around increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (seed_en) begin
            cnt <= seed_val;
        end else if (ce) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bdg_offset_stage.sv
// Module: staging and active registers for one delay value.
// Writes above MAXV are refused and flagged for one cycle. A load copies the
// value staged before the current edge; a write in the same cycle stays pending.
// Assumes: DW >= W.
module bdg_offset_stage #(
    parameter int MAXV = 2,
    parameter int DW   = 6,
    parameter int W    = bdg_pkg::bits_for(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          load,
    output logic [W-1:0]  staged,
    output logic [W-1:0]  active,
    output logic          pending,
    output logic          reject
);
    logic legal;
    logic accept;

    // Range check of the incoming write.
    always_comb begin
        legal  = (wr_data <= DW'(MAXV));
        accept = wr_en && legal;
    end

    // Staging register: takes only accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      staged <= '0;
        else if (accept) staged <= wr_data[W-1:0];
    end

    // Active register: takes the staged value on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= staged;
    end

    // Pending flag: set by an accepted write, cleared by a load alone.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (accept) pending <= 1'b1;
        else if (load)   pending <= 1'b0;
    end

    // Reject flag: one cycle after an out-of-range write.
    always_ff @(posedge clk) begin
        if (!rst_n) reject <= 1'b0;
        else        reject <= wr_en && !legal;
    end
endmodule

// File: rtl/bdg_shift_path.sv
// Module: one delayed wave path. A free-running modulo-PERIOD counter that,
// on a load, is re-seeded to (reference next count - new delay) mod PERIOD, so
// its wave is the reference wave delayed by the new delay from the next cycle.
// Assumes: ref_next is the reference count after this edge; new_delay < PERIOD.
module bdg_shift_path #(
    parameter int PERIOD = 3,
    parameter int HIGH   = 2,
    parameter int W      = bdg_pkg::bits_for(PERIOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ref_next,
    input  logic [W-1:0] new_delay,
    output logic         level
);
    logic [W:0]   diff;
    logic [W-1:0] seed;
    logic [W-1:0] cnt;

    // Seed arithmetic: modular subtraction without a divider.
    always_comb begin
        diff = {1'b0, ref_next} + (W+1)'(PERIOD) - {1'b0, new_delay};
        if (diff >= (W+1)'(PERIOD)) diff = diff - (W+1)'(PERIOD);
        seed = diff[W-1:0];
    end

    bdg_mod_counter #(.PERIOD(PERIOD), .W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (1'b1),
        .seed_en  (load),
        .seed_val (seed),
        .cnt      (cnt)
    );

    // Wave level decoded from the count.
    always_comb level = (cnt < W'(HIGH));
endmodule

// File: rtl/bucket_divgen.sv
// Module: top of the divided reference clock generator. A modulo-MID_DIV
// counter makes the middle-rate wave; a modulo-LOW_MULT counter advanced on
// each middle-rate wrap makes the low-rate wave. Two shift paths produce the
// delayed copies, steered by two offset stages behind one write port.
// Assumes: LOW_MULT is even; MID_DIV >= 2.
module bucket_divgen #(
    parameter int MID_DIV  = 3,
    parameter int LOW_MULT = 12,
    parameter int MW       = bdg_pkg::bits_for(MID_DIV),
    parameter int LW       = bdg_pkg::bits_for(MID_DIV * LOW_MULT),
    parameter int WR_W     = LW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [WR_W-1:0] wr_data,
    input  logic            load_strb,
    output logic            cw_mid,
    output logic            cw_low,
    output logic            sh_mid,
    output logic            sh_low,
    output logic [MW-1:0]   staged_mid,
    output logic [LW-1:0]   staged_low,
    output logic [MW-1:0]   active_mid,
    output logic [LW-1:0]   active_low,
    output logic            pending,
    output logic            wr_err
);
    localparam int LOW_DIV  = MID_DIV * LOW_MULT;
    localparam int MID_HIGH = MID_DIV - 1;
    localparam int LOW_HIGH = LOW_DIV / 2;
    localparam int CW       = bdg_pkg::bits_for(LOW_MULT);

    logic [MW-1:0] mid_cnt;
    logic [CW-1:0] crs_cnt;
    logic          mid_wrap;
    logic [MW-1:0] mid_next;
    logic [LW-1:0] low_abs;
    logic [LW-1:0] low_next;
    logic          pend_mid, pend_low;
    logic          rej_mid, rej_low;

    // Reference middle-rate counter, never re-seeded.
    bdg_mod_counter #(.PERIOD(MID_DIV), .W(MW)) u_mid (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (1'b1),
        .seed_en  (1'b0),
        .seed_val ('0),
        .cnt      (mid_cnt)
    );

    // Middle-rate wrap drives the coarse low-rate counter.
    always_comb mid_wrap = (mid_cnt == MW'(MID_DIV - 1));

    // Coarse low-rate counter: counts whole middle-rate periods.
    bdg_mod_counter #(.PERIOD(LOW_MULT), .W(CW)) u_crs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (mid_wrap),
        .seed_en  (1'b0),
        .seed_val ('0),
        .cnt      (crs_cnt)
    );

    // Continuous wave decode.
    always_comb begin
        cw_mid = (mid_cnt < MW'(MID_HIGH));
        cw_low = (crs_cnt < CW'(LOW_MULT / 2));
    end

    // Reference counts after this edge, used to seed the shift paths.
    always_comb begin
        mid_next = mid_wrap ? '0 : mid_cnt + 1'b1;
        low_abs  = LW'(crs_cnt) * LW'(MID_DIV) + LW'(mid_cnt);
        low_next = (low_abs == LW'(LOW_DIV - 1)) ? '0 : low_abs + 1'b1;
    end

    bdg_offset_stage #(.MAXV(MID_DIV - 1), .DW(WR_W), .W(MW)) u_stg_mid (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && !wr_sel),
        .wr_data (wr_data),
        .load    (load_strb),
        .staged  (staged_mid),
        .active  (active_mid),
        .pending (pend_mid),
        .reject  (rej_mid)
    );

    bdg_offset_stage #(.MAXV(LOW_DIV - 1), .DW(WR_W), .W(LW)) u_stg_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && wr_sel),
        .wr_data (wr_data),
        .load    (load_strb),
        .staged  (staged_low),
        .active  (active_low),
        .pending (pend_low),
        .reject  (rej_low)
    );

    bdg_shift_path #(.PERIOD(MID_DIV), .HIGH(MID_HIGH), .W(MW)) u_sh_mid (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_strb),
        .ref_next  (mid_next),
        .new_delay (staged_mid),
        .level     (sh_mid)
    );

    bdg_shift_path #(.PERIOD(LOW_DIV), .HIGH(LOW_HIGH), .W(LW)) u_sh_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_strb),
        .ref_next  (low_next),
        .new_delay (staged_low),
        .level     (sh_low)
    );

    // Combined status flags.
    always_comb begin
        pending = pend_mid || pend_low;
        wr_err  = rej_mid || rej_low;
    end
endmodule

// File: rtl/bucket_divgen_chk.sv
// Module: property checker for bucket_divgen, bound to every instance.
// Assumes: default parameter relations of the top (LOW_MULT even).
module bucket_divgen_chk #(
    parameter int MID_DIV  = 3,
    parameter int LOW_MULT = 12,
    parameter int MW       = 2,
    parameter int LW       = 6,
    parameter int WR_W     = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_sel,
    input logic [WR_W-1:0] wr_data,
    input logic            load_strb,
    input logic            cw_mid,
    input logic            cw_low,
    input logic            sh_mid,
    input logic            sh_low,
    input logic [MW-1:0]   staged_mid,
    input logic [LW-1:0]   staged_low,
    input logic [MW-1:0]   active_mid,
    input logic [LW-1:0]   active_low,
    input logic            pending,
    input logic            wr_err
);
    localparam int LOW_DIV = MID_DIV * LOW_MULT;

    AST_MID_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !cw_mid |=> cw_mid); // R1
    AST_LOW_RISE_ON_MID_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cw_low) |-> $rose(cw_mid)); // R2
    AST_ZERO_DELAY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) (active_mid == '0) |-> (sh_mid == cw_mid)); // R3
    AST_ZERO_DELAY_ALIGNED_LOW: assert property (@(posedge clk) disable iff (!rst_n) (active_low == '0) |-> (sh_low == cw_low)); // R3
    AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> ($stable(staged_mid) && $stable(staged_low))); // R4
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load_strb |=> ($stable(active_mid) && $stable(active_low))); // R5
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n) load_strb |=> (active_mid == $past(staged_mid) && active_low == $past(staged_low))); // R5
    AST_REJECT_LOW: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel && wr_data > WR_W'(LOW_DIV - 1)) |=> (wr_err && $stable(staged_low))); // R6
    AST_REJECT_MID: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_sel && wr_data > WR_W'(MID_DIV - 1)) |=> (wr_err && $stable(staged_mid))); // R6
    AST_PENDING_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (load_strb && !wr_en) |=> !pending); // R7
    AST_ACTIVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (active_mid <= MW'(MID_DIV - 1) && active_low <= LW'(LOW_DIV - 1))); // R9
endmodule

bind bucket_divgen bucket_divgen_chk #(
    .MID_DIV(MID_DIV), .LOW_MULT(LOW_MULT), .MW(MW), .LW(LW), .WR_W(WR_W)
) u_chk (.*);

// File: tb/test_bucket_divgen.sv
// Bench: cycle-by-cycle behavioural model of the generator, compared with
// every port on every clock. Inputs change and outputs are sampled on the
// falling edge.
module test_bucket_divgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [5:0] wr_data = '0;
    logic       load_strb = 1'b0;
    logic       cw_mid, cw_low, sh_mid, sh_low, pending, wr_err;
    logic [1:0] staged_mid, active_mid;
    logic [5:0] staged_low, active_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state
    int t = 0;
    int m_sm = 0, m_sl = 0, m_am = 0, m_al = 0;
    bit m_pend = 0, m_err = 0;
    string sweep_tag = "R3";
    int log_q[$];

    always #10 clk = ~clk;   // 50 MHz

    bucket_divgen i_bucket_divgen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .load_strb(load_strb),
        .cw_mid(cw_mid), .cw_low(cw_low), .sh_mid(sh_mid), .sh_low(sh_low),
        .staged_mid(staged_mid), .staged_low(staged_low),
        .active_mid(active_mid), .active_low(active_low),
        .pending(pending), .wr_err(wr_err)
    );

    function automatic int wave(input int ph, input int per, input int hi);
        int p = ((ph % per) + per) % per;
        return (p < hi) ? 1 : 0;
    endfunction

    task automatic chk(input string tag, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at t=%0d: actual %0d expected %0d", tag, name, t, act, exp);
        end
    endtask

    task automatic compare(input bit in_reset);
        string tw = in_reset ? "R8" : "";
        chk(in_reset ? tw : "R1", "cw_mid", int'(cw_mid), wave(t, 3, 2));
        chk(in_reset ? tw : "R2", "cw_low", int'(cw_low), wave(t, 36, 18));
        chk(in_reset ? tw : "R3", "sh_mid", int'(sh_mid), wave(t - m_am, 3, 2));
        chk(in_reset ? tw : sweep_tag, "sh_low", int'(sh_low), wave(t - m_al, 36, 18));
        chk(in_reset ? tw : "R4", "staged_mid", int'(staged_mid), m_sm);
        chk(in_reset ? tw : "R4", "staged_low", int'(staged_low), m_sl);
        chk(in_reset ? tw : "R5", "active_mid", int'(active_mid), m_am);
        chk(in_reset ? tw : "R5", "active_low", int'(active_low), m_al);
        chk(in_reset ? tw : "R7", "pending", int'(pending), int'(m_pend));
        chk(in_reset ? tw : "R6", "wr_err", int'(wr_err), int'(m_err));
    endtask

    // One reference cycle with the given inputs; model advances at the edge.
    task automatic cyc(input bit we, input bit sel, input int dat, input bit ld);
        bit bad, acc;
        wr_en = we; wr_sel = sel; wr_data = 6'(dat); load_strb = ld;
        @(posedge clk);
        bad = we && ((!sel && dat > 2) || (sel && dat > 35));
        acc = we && !bad;
        if (ld) begin m_am = m_sm; m_al = m_sl; end
        if (acc) begin
            if (sel) m_sl = dat; else m_sm = dat;
            log_q.push_back(dat);
        end
        m_pend = acc ? 1'b1 : (ld ? 1'b0 : m_pend);
        m_err  = bad;
        t++;
        @(negedge clk);
        compare(1'b0);
        wr_en = 1'b0; load_strb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            t = 0; m_sm = 0; m_sl = 0; m_am = 0; m_al = 0; m_pend = 0; m_err = 0;
            @(negedge clk);
            compare(1'b1);   // R8: all waves high, delays zero
        end
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset(3);
        idle(40);                           // R1 R2 free running
        cyc(1, 0, 1, 0);                    // R4 stage mid delay 1
        idle(10);                           // R4 no effect before load
        cyc(0, 0, 0, 1);                    // R5 load
        idle(12);
        cyc(1, 1, 7, 0);                    // R4 stage low delay 7
        idle(40);
        cyc(0, 0, 0, 1);                    // R5 R7
        idle(40);
        cyc(1, 0, 3, 0);                    // R6 mid just out of range
        cyc(1, 1, 36, 0);                   // R6 low just out of range
        cyc(1, 1, 63, 0);                   // R6 maximum code
        idle(3);
        cyc(1, 1, 35, 0);                   // R9 top legal value
        cyc(1, 1, 20, 1);                   // R7 write and load together
        idle(40);
        cyc(0, 0, 0, 1);                    // R7 load picks up 20
        idle(40);
        sweep_tag = "R9";
        for (int d = 0; d < 36; d++) begin  // R9 every low-rate delay
            cyc(1, 1, d, 0);
            cyc(1, 0, d % 3, 0);
            idle(d % 5);
            cyc(0, 0, 0, 1);
            idle(37);
        end
        sweep_tag = "R3";
        do_reset(2);                        // R8 reset in mid run
        idle(40);
        if (log_q.size() == 0) begin
            fails++;
            $display("FAIL R4 write log: actual 0 expected nonzero");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule